// File: doc/BRIEF.md
# SRAM-Style Access Cycle Controller

This block sits between an asynchronous, SRAM-like pin interface and a synchronous behavioural word array. It brings every pin into the local clock domain, watches the synchronized chip enable, write enable and address for edges and changes, and works out what kind of memory cycle the host is running. It then sends the array exactly one single-cycle read or write strobe per access. Each strobe carries an address, a byte-lane mask and a tag that names the cycle type.

A read starts either when chip enable falls while write enable is high, or when the address moves while chip enable stays low. A move confined to the low column bits is a page read. A move in the upper bits is a new random read. A write is owned by chip enable when write enable is already low as chip enable falls, and it commits when chip enable rises. Otherwise a write enable pulse inside a chip-enable-low window commits on its rising edge, at the address captured on its falling edge.

Read data is sent back per byte lane through a separate output and enable pair. A supply-low input stops every array strobe while it is asserted.

Top module: `sram_cycle_ctl`

## Requirements
- R1: After reset, neither array strobe is asserted and both data lane enables are low.
- R2: A chip-enable fall with write enable high issues one read strobe at the current address with tag 0 (random read). The word returned by the array then appears on the data output.
- R3: A chip-enable fall with write enable already low starts a chip-enable-owned write. When chip enable rises, one write strobe is issued with tag 2, at the address held at the fall, carrying the data present at the rise.
- R4: With chip enable low and write enable high at the start, a write-enable rise issues one write strobe with tag 3. The strobe carries the address held at the matching write-enable fall, and the data present at the rise.
- R5: While chip enable is low and write enable is high, an address change limited to the low COL_W bits issues a read with tag 1 (page read). A change that touches any upper bit issues a read with tag 0.
- R6: While write enable is low, neither data lane enable is asserted, whatever the level of output enable.
- R7: The lane mask has bit 1 set for the upper byte (upper enable low) and bit 0 set for the lower byte (lower enable low). The data lane enables follow the same bit positions.
- R8: While the supply-low input is asserted, no read or write strobe reaches the array. Array contents therefore stay unchanged, and no read completes.
- R9: A lane enable is asserted only while chip enable and output enable are low, write enable is high, that lane is selected, and a read has completed. It drops within one cycle after the synchronized condition stops holding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| ub_n | input | 1 | Upper byte enable, active low |
| lb_n | input | 1 | Lower byte enable, active low |
| addr_i | input | ADDR_W | Word address |
| dq_i | input | 16 | Data bus, input side |
| dq_o | output | 16 | Data bus, output side |
| dq_oe_o | output | 2 | Per-lane output enable for the data bus (bit 1 upper) |
| supply_low_i | input | 1 | Low-supply inhibit, active high |
| arr_rd_o | output | 1 | Single-cycle array read strobe |
| arr_wr_o | output | 1 | Single-cycle array write strobe |
| arr_addr_o | output | ADDR_W | Array address for the strobe |
| arr_mask_o | output | 2 | Byte-lane mask for the strobe (bit 1 upper) |
| arr_wdata_o | output | 16 | Array write data |
| arr_kind_o | output | 2 | Cycle tag: 0 random read, 1 page read, 2 chip-enable write, 3 write-enable write |
| arr_rdata_i | input | 16 | Array read data, valid in the cycle of the read strobe |

## Verification
The bench builds the block with ADDR_W set to 8, COL_W set to 2 and SYNC_STAGES set to 2. The array model then needs only 256 words, while address moves inside one four-word page and moves across pages both stay cheap to produce. With these widths the bench can drive both write ownership rules, a page write followed by an address change while write enable is low, single-lane writes and reads, and an inhibited read and write. Each of these is followed by a read-back through the normal pins.

// File: rtl/scc_pkg.sv
package scc_pkg;
    localparam int DATA_W = 16;
    localparam int LANES  = DATA_W / 8;

    typedef enum logic [1:0] {
        KIND_RAND_RD = 2'd0,
        KIND_PAGE_RD = 2'd1,
        KIND_CE_WR   = 2'd2,
        KIND_WE_WR   = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        M_IDLE = 2'd0,
        M_ACT  = 2'd1,
        M_WRCE = 2'd2
    } mode_e;
endpackage

// File: rtl/scc_sync.sv
module scc_sync #(
    parameter int          W      = 1,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] RST   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[s] <= RST;
                end else if (s == 0) begin
                    chain_q[s] <= d;
                end else begin
                    chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/scc_ctrl.sv
module scc_ctrl
    import scc_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int COL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [LANES-1:0]  lane_n,
    input  logic              lowv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              rd_o,
    output logic              wr_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [LANES-1:0]  mask_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [1:0]        kind_o,
    output logic [DATA_W-1:0] dq_o,
    output logic [LANES-1:0]  dq_oe_o
);
    typedef struct packed {
        mode_e              mode;
        logic               ce_p;
        logic               we_p;
        logic [ADDR_W-1:0]  addr_p;
        logic [ADDR_W-1:0]  waddr;
        logic               rd;
        logic               wr;
        logic [ADDR_W-1:0]  aaddr;
        logic [LANES-1:0]   mask;
        logic [DATA_W-1:0]  wdata;
        acc_kind_e          kind;
        logic               rvalid;
        logic [DATA_W-1:0]  rdata;
        logic [LANES-1:0]   oe;
    } st_t;

    st_t st_d, st_q;

    logic ce_fall, ce_rise, we_fall, we_rise, addr_chg, hi_chg;
    logic rd_req, wr_req;
    acc_kind_e kind_sel;

    always_comb begin
        ce_fall  = st_q.ce_p & ~ce_n;
        ce_rise  = ~st_q.ce_p & ce_n;
        we_fall  = st_q.we_p & ~we_n;
        we_rise  = ~st_q.we_p & we_n;
        addr_chg = (addr != st_q.addr_p);
        hi_chg   = (addr[ADDR_W-1:COL_W] != st_q.addr_p[ADDR_W-1:COL_W]);

        st_d        = st_q;
        st_d.rd     = 1'b0;
        st_d.wr     = 1'b0;
        st_d.ce_p   = ce_n;
        st_d.we_p   = we_n;
        st_d.addr_p = addr;
        rd_req      = 1'b0;
        wr_req      = 1'b0;
        kind_sel    = KIND_RAND_RD;

        unique case (st_q.mode)
            M_IDLE: begin
                if (ce_fall) begin
                    if (!we_n) begin
                        st_d.mode  = M_WRCE;
                        st_d.waddr = addr;
                    end else begin
                        st_d.mode = M_ACT;
                        rd_req    = 1'b1;
                        kind_sel  = KIND_RAND_RD;
                    end
                end
            end
            M_WRCE: begin
                if (ce_rise) begin
                    st_d.mode = M_IDLE;
                    wr_req    = 1'b1;
                    kind_sel  = KIND_CE_WR;
                end else if (we_rise) begin
                    st_d.mode = M_ACT;
                    wr_req    = 1'b1;
                    kind_sel  = KIND_WE_WR;
                end
            end
            M_ACT: begin
                if (ce_rise) begin
                    st_d.mode = M_IDLE;
                    if (we_rise) begin
                        wr_req   = 1'b1;
                        kind_sel = KIND_WE_WR;
                    end
                end else if (we_fall) begin
                    st_d.waddr = addr;
                end else if (we_rise) begin
                    wr_req   = 1'b1;
                    kind_sel = KIND_WE_WR;
                end else if (we_n && addr_chg) begin
                    rd_req   = 1'b1;
                    kind_sel = hi_chg ? KIND_RAND_RD : KIND_PAGE_RD;
                end
            end
            default: st_d.mode = M_IDLE;
        endcase

        if (!lowv && (rd_req || wr_req)) begin
            st_d.rd    = rd_req;
            st_d.wr    = wr_req;
            st_d.aaddr = rd_req ? addr : st_q.waddr;
            st_d.mask  = ~lane_n;
            st_d.wdata = din;
            st_d.kind  = kind_sel;
        end

        if (st_q.rd) begin
            st_d.rvalid = 1'b1;
            st_d.rdata  = rdata_i;
        end
        if (rd_req || ce_rise || we_fall || lowv) begin
            st_d.rvalid = 1'b0;
        end

        for (int i = 0; i < LANES; i++) begin
            st_d.oe[i] = ~ce_n & ~oe_n & we_n & st_q.rvalid & ~lane_n[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.mode   <= M_IDLE;
            st_q.ce_p   <= 1'b1;
            st_q.we_p   <= 1'b1;
            st_q.kind   <= KIND_RAND_RD;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_o    = st_q.rd;
    assign wr_o    = st_q.wr;
    assign addr_o  = st_q.aaddr;
    assign mask_o  = st_q.mask;
    assign wdata_o = st_q.wdata;
    assign kind_o  = st_q.kind;
    assign dq_o    = st_q.rdata;
    assign dq_oe_o = st_q.oe;

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.rd && st_q.wr)); // R2
    AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wr |=> !st_q.wr); // R4
    AST_NO_DRIVE_WE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |=> (st_q.oe == '0)); // R6
    AST_INHIBIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        lowv |=> (!st_q.rd && !st_q.wr)); // R8
    AST_NO_DRIVE_CE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (st_q.oe == '0)); // R9
endmodule

// File: rtl/sram_cycle_ctl.sv
module sram_cycle_ctl
    import scc_pkg::*;
#(
    parameter int ADDR_W      = 17,
    parameter int COL_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              ub_n,
    input  logic              lb_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [15:0]       dq_i,
    output logic [15:0]       dq_o,
    output logic [1:0]        dq_oe_o,
    input  logic              supply_low_i,
    output logic              arr_rd_o,
    output logic              arr_wr_o,
    output logic [ADDR_W-1:0] arr_addr_o,
    output logic [1:0]        arr_mask_o,
    output logic [15:0]       arr_wdata_o,
    output logic [1:0]        arr_kind_o,
    input  logic [15:0]       arr_rdata_i
);
    localparam int CTL_W = 6;
    localparam int DAT_W = ADDR_W + DATA_W;

    logic [CTL_W-1:0] ctl_s;
    logic [DAT_W-1:0] dat_s;

    scc_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST(6'b011111)) u_ctl_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({supply_low_i, ce_n, we_n, oe_n, ub_n, lb_n}),
        .q     (ctl_s)
    );

    scc_sync #(.W(DAT_W), .STAGES(SYNC_STAGES), .RST('0)) u_dat_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({addr_i, dq_i}),
        .q     (dat_s)
    );

    scc_ctrl #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ctl_s[4]),
        .we_n    (ctl_s[3]),
        .oe_n    (ctl_s[2]),
        .lane_n  (ctl_s[1:0]),
        .lowv    (ctl_s[5]),
        .addr    (dat_s[DAT_W-1:DATA_W]),
        .din     (dat_s[DATA_W-1:0]),
        .rdata_i (arr_rdata_i),
        .rd_o    (arr_rd_o),
        .wr_o    (arr_wr_o),
        .addr_o  (arr_addr_o),
        .mask_o  (arr_mask_o),
        .wdata_o (arr_wdata_o),
        .kind_o  (arr_kind_o),
        .dq_o    (dq_o),
        .dq_oe_o (dq_oe_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!arr_rd_o && !arr_wr_o && dq_oe_o == 2'b00)); // R1
endmodule

// File: tb/sim_sram_cycle_ctl.sv
module sim_sram_cycle_ctl;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, ub_n = 1'b0, lb_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0]   dq_i = '0;
    logic [15:0]   dq_o;
    logic [1:0]    dq_oe;
    logic          supply_low = 1'b0;
    logic          arr_rd, arr_wr;
    logic [AW-1:0] arr_addr;
    logic [1:0]    arr_mask, arr_kind;
    logic [15:0]   arr_wdata, arr_rdata;
    logic [15:0]   mem [256];

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    sram_cycle_ctl #(.ADDR_W(AW), .COL_W(2), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .ub_n(ub_n), .lb_n(lb_n), .addr_i(addr), .dq_i(dq_i), .dq_o(dq_o),
        .dq_oe_o(dq_oe), .supply_low_i(supply_low), .arr_rd_o(arr_rd),
        .arr_wr_o(arr_wr), .arr_addr_o(arr_addr), .arr_mask_o(arr_mask),
        .arr_wdata_o(arr_wdata), .arr_kind_o(arr_kind), .arr_rdata_i(arr_rdata)
    );

    assign arr_rdata = mem[arr_addr];

    always @(posedge clk) begin
        if (arr_wr) begin
            if (arr_mask[0]) mem[arr_addr][7:0]  <= arr_wdata[7:0];
            if (arr_mask[1]) mem[arr_addr][15:8] <= arr_wdata[15:8];
        end
    end

    typedef struct packed {
        logic          wr;
        logic [1:0]    kind;
        logic [AW-1:0] addr;
        logic [1:0]    mask;
        logic [15:0]   data;
    } exp_t;

    exp_t  eq[$];
    string rq[$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push(input logic wr, input logic [1:0] kind, input logic [AW-1:0] a,
                        input logic [1:0] m, input logic [15:0] d, input string req);
        exp_t e;
        e.wr = wr; e.kind = kind; e.addr = a; e.mask = m; e.data = d;
        eq.push_back(e);
        rq.push_back(req);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops expected strobes and compares
    always @(negedge clk) begin
        exp_t  e;
        string r;
        if (rst_n && (arr_rd || arr_wr)) begin
            if (eq.size() == 0) begin
                chk(1'b0, "R8 unexpected strobe", {22'd0, arr_wr, arr_rd, arr_addr}, 32'd0);
            end else begin
                e = eq.pop_front();
                r = rq.pop_front();
                chk(arr_wr == e.wr, r, {31'd0, arr_wr}, {31'd0, e.wr});
                chk(arr_kind == e.kind, r, {30'd0, arr_kind}, {30'd0, e.kind});
                chk(arr_addr == e.addr, r, {24'd0, arr_addr}, {24'd0, e.addr});
                if (e.wr) begin
                    chk(arr_mask == e.mask, r, {30'd0, arr_mask}, {30'd0, e.mask});
                    chk(arr_wdata == e.data, r, {16'd0, arr_wdata}, {16'd0, e.data});
                end
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        // R1 reset state
        chk(!arr_rd && !arr_wr, "R1", {30'd0, arr_rd, arr_wr}, 32'd0);
        chk(dq_oe == 2'b00, "R1", {30'd0, dq_oe}, 32'd0);

        // R3 chip-enable-owned write
        we_n = 1'b0;
        cyc(5);
        push(1'b1, 2'd2, 8'h14, 2'b11, 16'hA5C3, "R3");
        addr = 8'h14; ce_n = 1'b0;
        cyc(6);
        dq_i = 16'hA5C3;
        cyc(4);
        ce_n = 1'b1;
        cyc(6);
        we_n = 1'b1;
        cyc(6);

        // R2 random read on chip-enable fall
        push(1'b0, 2'd0, 8'h14, 2'b00, 16'h0, "R2");
        oe_n = 1'b0; ce_n = 1'b0;
        cyc(8);
        chk(dq_oe == 2'b11, "R9", {30'd0, dq_oe}, 32'd3);
        chk(dq_o == 16'hA5C3, "R2", {16'd0, dq_o}, 32'hA5C3);

        // R5 page read, then random read on upper change
        push(1'b0, 2'd1, 8'h15, 2'b00, 16'h0, "R5");
        addr = 8'h15;
        cyc(8);
        chk(dq_o == 16'h0000, "R5", {16'd0, dq_o}, 32'd0);
        push(1'b0, 2'd0, 8'h24, 2'b00, 16'h0, "R5");
        addr = 8'h24;
        cyc(8);

        // R4 write-enable-owned page write, upper lane only (R7)
        ub_n = 1'b0; lb_n = 1'b1;
        push(1'b0, 2'd1, 8'h25, 2'b00, 16'h0, "R5");
        addr = 8'h25;
        cyc(8);
        push(1'b1, 2'd3, 8'h25, 2'b10, 16'h1234, "R4");
        we_n = 1'b0;
        cyc(6);
        chk(dq_oe == 2'b00, "R6", {30'd0, dq_oe}, 32'd0);
        addr = 8'h26; dq_i = 16'h1234;
        cyc(6);
        chk(dq_oe == 2'b00, "R6", {30'd0, dq_oe}, 32'd0);
        we_n = 1'b1;
        cyc(8);
        push(1'b0, 2'd1, 8'h25, 2'b00, 16'h0, "R5");
        addr = 8'h25;
        cyc(8);
        chk(dq_oe == 2'b10, "R7", {30'd0, dq_oe}, 32'd2);
        chk(dq_o == 16'h1200, "R7", {16'd0, dq_o}, 32'h1200);

        // R9 release and return with output enable, release on chip-enable rise
        oe_n = 1'b1;
        cyc(5);
        chk(dq_oe == 2'b00, "R9", {30'd0, dq_oe}, 32'd0);
        oe_n = 1'b0;
        cyc(5);
        chk(dq_oe == 2'b10, "R9", {30'd0, dq_oe}, 32'd2);
        ce_n = 1'b1;
        cyc(6);
        chk(dq_oe == 2'b00, "R9", {30'd0, dq_oe}, 32'd0);

        // R8 inhibit: no read, no write
        ub_n = 1'b0; lb_n = 1'b0;
        supply_low = 1'b1;
        cyc(5);
        addr = 8'h30; ce_n = 1'b0;
        cyc(10);
        chk(dq_oe == 2'b00, "R8", {30'd0, dq_oe}, 32'd0);
        ce_n = 1'b1;
        cyc(5);
        we_n = 1'b0;
        cyc(5);
        addr = 8'h14; dq_i = 16'hFFFF; ce_n = 1'b0;
        cyc(6);
        ce_n = 1'b1;
        cyc(6);
        we_n = 1'b1;
        cyc(5);
        supply_low = 1'b0;
        cyc(5);
        push(1'b0, 2'd0, 8'h14, 2'b00, 16'h0, "R8");
        ce_n = 1'b0;
        cyc(8);
        chk(dq_o == 16'hA5C3, "R8", {16'd0, dq_o}, 32'hA5C3);
        ce_n = 1'b1;
        cyc(6);

        // R7 lower-lane-only chip-enable write, then full read back
        ub_n = 1'b1; lb_n = 1'b0;
        we_n = 1'b0;
        cyc(5);
        push(1'b1, 2'd2, 8'h40, 2'b01, 16'hBEEF, "R7");
        addr = 8'h40; dq_i = 16'hBEEF; ce_n = 1'b0;
        cyc(6);
        ce_n = 1'b1;
        cyc(6);
        we_n = 1'b1;
        ub_n = 1'b0;
        cyc(5);
        push(1'b0, 2'd0, 8'h40, 2'b00, 16'h0, "R2");
        ce_n = 1'b0;
        cyc(8);
        chk(dq_o == 16'h00EF, "R7", {16'd0, dq_o}, 32'h00EF);
        chk(dq_oe == 2'b11, "R7", {30'd0, dq_oe}, 32'd3);
        ce_n = 1'b1;
        cyc(8);

        chk(eq.size() == 0, "R2 pending strobes", eq.size(), 32'd0);
        finish_run();
    end
endmodule